// File: doc/BRIEF.md
# ECC Error Logging Unit

This block sits next to a memory bus controller and records the error reports that the controller raises. Each report arrives as a one-cycle pulse that carries an error kind (single-bit, multi-bit or bus abort), an 8-bit syndrome, a transfer direction and the 32-bit failing address. The unit stores up to two reports in two log slots. Each slot has a log word and a matching address word. A valid flag marks each occupied slot, and a sticky overflow flag records any report that arrived while both slots were full.

Software reaches the unit through a simple register port. The port has a combinational read path and a single-cycle write strobe. A control/status word holds the enable bits and the flags. A mode word holds one stored option bit. The log and address words are read-only. An interrupt request stays high for as long as any slot holds an unread report. Software reads the slots and then releases them by writing ones to the matching flags.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Control word (register address 0): bit 0 (single-bit report enable), bit 2 (single-bit correct enable) and bit 3 (checking enable) are read/write. Bit 31 reads the live `busPending` input. Bits 28, 29 and 30 are the flags of R5 to R7. All other bits read zero.
- R3: While control bit 3 is clear, a report of any kind changes no flag and no slot.
- R4: Error kind codes are 0 for single-bit, 1 for multi-bit and 2 for bus abort. A single-bit report made while control bit 0 is clear is neither logged nor counted as overflow.
- R5: A logged report goes to the lowest-numbered free slot. Slot 0 log and address words are at register addresses 2 and 4. Slot 1 log and address words are at addresses 3 and 5. Control bits 28 and 29 are the valid flags of slots 0 and 1, and they are set one cycle after the report. A log word holds the syndrome in bits 7:0, the kind in bits 30:29 and the direction in bit 31 (1 = write). Its other bits are zero.
- R6: A logged report that arrives while both slots are valid is dropped. It sets control bit 30, which stays set, and both slots keep their contents.
- R7: Writing 1 to control bit 28, 29 or 30 clears that flag. Writing 0 to it leaves the flag unchanged.
- R8: `irq` is high exactly when control bit 28 or bit 29 is set.
- R9: Mode word (address 1) bit 0 is stored and read back, and its other bits read zero. Writes to addresses 2 to 5 are ignored. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| errValid | input | 1 | One-cycle error report pulse |
| errKind | input | 2 | Error kind: 0 single-bit, 1 multi-bit, 2 bus abort |
| errSyndrome | input | 8 | Syndrome of the report |
| errWrite | input | 1 | Direction of the failing transfer, 1 = write |
| errAddr | input | 32 | Failing address |
| busPending | input | 1 | Bus transactions are outstanding |
| regAddr | input | 3 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong valid flag shows in two places on the very next cycle after the report: in the control word read-back and on `irq`. A misplaced slot selection shows at the same point, as the wrong flag set together with a log word in the wrong address. A lost or spurious overflow shows on bit 30 one cycle after the third logged report. Enable-policy faults are caught by reading the control and log words right after a report that should have been ignored.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int SYN_W = 8;
  localparam int DATA_W = 32;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_MODE  = 3'd1;
  localparam logic [2:0] REG_LOG0  = 3'd2;
  localparam logic [2:0] REG_LOG1  = 3'd3;
  localparam logic [2:0] REG_ADDR0 = 3'd4;
  localparam logic [2:0] REG_ADDR1 = 3'd5;

  localparam int BIT_SB_REPORT = 0;
  localparam int BIT_SB_FIX    = 2;
  localparam int BIT_CHECK_ON  = 3;
  localparam int BIT_VALID0    = 28;
  localparam int BIT_VALID1    = 29;
  localparam int BIT_OVF       = 30;
  localparam int BIT_PENDING   = 31;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_MULTI  = 2'd1,
    KIND_ABORT  = 2'd2
  } errKind_e;

  typedef struct packed {
    logic capture0;
    logic capture1;
  } logStrobe_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              errValid,
  input  logic [1:0]        errKind,
  input  logic              busPending,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logStrobe_t        strobe,
  output logic [DATA_W-1:0] statusWord,
  output logic              modeBit,
  output logic              irq
);
  logic sbReport, sbFix, checkOn;
  logic valid0, valid1, ovfFlag;
  logic reportable, ovfHit, ctrlWr, modeWr;

  assign reportable = errValid && checkOn &&
                      ((errKind != KIND_SINGLE) || sbReport);
  assign strobe.capture0 = reportable && !valid0;
  assign strobe.capture1 = reportable && valid0 && !valid1;
  assign ovfHit = reportable && valid0 && valid1;

  assign ctrlWr = regWrEn && (regAddr == REG_CTRL);
  assign modeWr = regWrEn && (regAddr == REG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbReport <= 1'b0;
      sbFix    <= 1'b0;
      checkOn  <= 1'b0;
      valid0   <= 1'b0;
      valid1   <= 1'b0;
      ovfFlag  <= 1'b0;
      modeBit  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        sbReport <= regWrData[BIT_SB_REPORT];
        sbFix    <= regWrData[BIT_SB_FIX];
        checkOn  <= regWrData[BIT_CHECK_ON];
      end
      if (modeWr) modeBit <= regWrData[0];
      valid0  <= strobe.capture0 | (valid0 & ~(ctrlWr & regWrData[BIT_VALID0]));
      valid1  <= strobe.capture1 | (valid1 & ~(ctrlWr & regWrData[BIT_VALID1]));
      ovfFlag <= ovfHit | (ovfFlag & ~(ctrlWr & regWrData[BIT_OVF]));
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[BIT_SB_REPORT] = sbReport;
    statusWord[BIT_SB_FIX]    = sbFix;
    statusWord[BIT_CHECK_ON]  = checkOn;
    statusWord[BIT_VALID0]    = valid0;
    statusWord[BIT_VALID1]    = valid1;
    statusWord[BIT_OVF]       = ovfFlag;
    statusWord[BIT_PENDING]   = busPending;
  end

  assign irq = valid0 | valid1;
endmodule

// File: rtl/ecc_log_data.sv
module ecc_log_data
  import ecc_log_pkg::*;
#(
  parameter int SLOTS = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logStrobe_t        strobe,
  input  logic [1:0]        errKind,
  input  logic [SYN_W-1:0]  errSyndrome,
  input  logic              errWrite,
  input  logic [DATA_W-1:0] errAddr,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] statusWord,
  input  logic              modeBit,
  output logic [DATA_W-1:0] regRdData
);
  localparam int PAD_W = DATA_W - SYN_W - 3;

  logic [DATA_W-1:0] logWord [SLOTS];
  logic [DATA_W-1:0] addrWord [SLOTS];
  logic [SLOTS-1:0]  capture;
  logic [DATA_W-1:0] newLog;

  assign capture = {strobe.capture1, strobe.capture0};
  assign newLog  = {errWrite, errKind, {PAD_W{1'b0}}, errSyndrome};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        logWord[s]  <= '0;
        addrWord[s] <= '0;
      end else if (capture[s]) begin
        logWord[s]  <= newLog;
        addrWord[s] <= errAddr;
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_CTRL:  regRdData = statusWord;
      REG_MODE:  regRdData = {{(DATA_W-1){1'b0}}, modeBit};
      REG_LOG0:  regRdData = logWord[0];
      REG_LOG1:  regRdData = logWord[1];
      REG_ADDR0: regRdData = addrWord[0];
      REG_ADDR1: regRdData = addrWord[1];
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        errValid,
  input  logic [1:0]  errKind,
  input  logic [7:0]  errSyndrome,
  input  logic        errWrite,
  input  logic [31:0] errAddr,
  input  logic        busPending,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq
);
  logStrobe_t  strobe;
  logic [31:0] statusWord;
  logic        modeBit;

  ecc_log_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .errValid(errValid), .errKind(errKind),
    .busPending(busPending), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .strobe(strobe), .statusWord(statusWord),
    .modeBit(modeBit), .irq(irq)
  );

  ecc_log_data #(.SLOTS(2)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .errKind(errKind),
    .errSyndrome(errSyndrome), .errWrite(errWrite), .errAddr(errAddr),
    .regAddr(regAddr), .statusWord(statusWord), .modeBit(modeBit),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/ecc_err_log_checker.sv
module ecc_err_log_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        errValid,
  input logic [1:0]  errKind,
  input logic        busPending,
  input logic        regWrEn,
  input logic [31:0] statusWord,
  input logic        irq
);
  // R8: interrupt follows the two valid flags
  assert_irq_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (statusWord[28] | statusWord[29]));

  // R2: pending bit mirrors the bus input
  assert_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    statusWord[31] == busPending);

  // R6: a logged report with both slots full raises overflow
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (errValid && !regWrEn && statusWord[3] && statusWord[28] && statusWord[29] &&
     (errKind != 2'd0 || statusWord[0])) |=> statusWord[30]);

  // R4: unreported single-bit errors leave the flags alone
  assert_sb_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (errValid && !regWrEn && errKind == 2'd0 && !statusWord[0])
      |=> $stable(statusWord[30:28]));

  // R3: nothing is logged while checking is off
  assert_check_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (errValid && !regWrEn && !statusWord[3]) |=> $stable(statusWord[30:28]));
endmodule

bind ecc_err_log ecc_err_log_checker u_chk (
  .clk(clk), .rst_n(rst_n), .errValid(errValid), .errKind(errKind),
  .busPending(busPending), .regWrEn(regWrEn), .statusWord(statusWord),
  .irq(irq)
);

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        errValid = 1'b0;
  logic [1:0]  errKind = '0;
  logic [7:0]  errSyndrome = '0;
  logic        errWrite = 1'b0;
  logic [31:0] errAddr = '0;
  logic        busPending = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int vecCount = 0;
  int missCount = 0;
  logic rdReq = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];
  bit doneFlag = 1'b0;

  always #5 clk = ~clk;

  ecc_err_log uut (.*);

  // monitor: pops one expectation per read request
  always @(posedge clk) begin
    if (rdReq && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      vecCount++;
      if (regRdData !== e) begin
        missCount++;
        $display("FAIL %s: read addr %0d got %h expected %h", t, regAddr, regRdData, e);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    regAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic report(input logic [1:0] k, input logic [7:0] syn,
                        input logic w, input logic [31:0] adr);
    errKind = k; errSyndrome = syn; errWrite = w; errAddr = adr; errValid = 1'b1;
    @(negedge clk);
    errValid = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    vecCount++;
    if (irq !== e) begin
      missCount++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd2, 32'h0, "R1 log0");
    rd(3'd5, 32'h0, "R1 addr1");
    chkIrq(1'b0, "R1");
    // R2 control fields
    wr(3'd0, 32'h0F00_FFFF & ~32'h7000_0000);
    rd(3'd0, 32'h0000_000D, "R2 rw bits");
    busPending = 1'b1;
    rd(3'd0, 32'h8000_000D, "R2 pending");
    busPending = 1'b0;
    // R3 checking off
    wr(3'd0, 32'h0);
    report(2'd1, 8'hAA, 1'b0, 32'h1);
    rd(3'd0, 32'h0, "R3 no flag");
    rd(3'd2, 32'h0, "R3 no log");
    chkIrq(1'b0, "R3");
    // R4 single-bit ignored when reporting disabled
    wr(3'd0, 32'h8);
    report(2'd0, 8'h44, 1'b1, 32'h2);
    rd(3'd0, 32'h0000_0008, "R4 sb dropped");
    rd(3'd2, 32'h0, "R4 no log");
    // R5 multi-bit write into slot 0
    report(2'd1, 8'h5A, 1'b1, 32'h1234_5678);
    chkIrq(1'b1, "R8 set");
    rd(3'd0, 32'h1000_0008, "R5 valid0");
    rd(3'd2, 32'hA000_005A, "R5 log0");
    rd(3'd4, 32'h1234_5678, "R5 addr0");
    // R7 zero writes keep flags
    wr(3'd0, 32'h9);
    rd(3'd0, 32'h1000_0009, "R7 keep");
    // R5 single-bit, reporting on, into slot 1
    report(2'd0, 8'h33, 1'b0, 32'hDEAD_0000);
    rd(3'd0, 32'h3000_0009, "R5 valid1");
    rd(3'd3, 32'h0000_0033, "R5 log1");
    rd(3'd5, 32'hDEAD_0000, "R5 addr1");
    // R6 overflow
    report(2'd2, 8'h77, 1'b1, 32'hFFFF_0000);
    rd(3'd0, 32'h7000_0009, "R6 ovf");
    rd(3'd2, 32'hA000_005A, "R6 log0 kept");
    rd(3'd5, 32'hDEAD_0000, "R6 addr1 kept");
    // R7 clear slot 0, then bus abort fills slot 0 again
    wr(3'd0, 32'h1000_0009);
    rd(3'd0, 32'h6000_0009, "R7 clear v0");
    chkIrq(1'b1, "R8 one slot");
    report(2'd2, 8'h11, 1'b0, 32'h0000_CAFE);
    rd(3'd0, 32'h7000_0009, "R5 refill");
    rd(3'd2, 32'h4000_0011, "R5 abort log");
    rd(3'd4, 32'h0000_CAFE, "R5 abort addr");
    wr(3'd0, 32'h7000_0009);
    rd(3'd0, 32'h0000_0009, "R7 clear all");
    chkIrq(1'b0, "R8 clear");
    // R9 mode and read-only words
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 32'h1, "R9 mode");
    wr(3'd2, 32'h0000_FFFF);
    wr(3'd5, 32'h0);
    rd(3'd2, 32'h4000_0011, "R9 log ro");
    rd(3'd5, 32'hDEAD_0000, "R9 addr ro");
    rd(3'd7, 32'h0, "R9 unmapped");
    wr(3'd1, 32'h0);
    rd(3'd1, 32'h0, "R9 mode clr");
    @(negedge clk);
    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!doneFlag) begin
      missCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule